// File: doc/BRIEF.md
# Single-Step Shift and Rotate Unit with Condition Flags

This unit moves an operand one bit position left or right and reports the carry, overflow, negative and zero flags for the step. It accepts three operand classes: a 36-bit accumulator, a 32-bit register and a 16-bit register. It offers six operations: arithmetic left, arithmetic right, logical left, logical right, rotate left through carry and rotate right through carry. Arithmetic steps act on the full width of the class.

Logical steps and rotates act only on one 16-bit word. For the accumulator and for the 32-bit register this is bits 31:16. For the 16-bit register it is bits 15:0. The bits outside that word pass through unchanged.

A request is sampled on a clock edge while `in_valid` is high. The shifted value and the four flags appear on the registered outputs one cycle later. Between requests the outputs hold their values.

Top module: `shr_unit`

## Requirements
- R1: Reset (active-low `rst_n`) clears `out_valid`, `result` and all flags. `out_valid` equals `in_valid` of the previous cycle. `result` and the flags update one cycle after a sampled request and hold while `in_valid` is low.
- R2: Arithmetic left (`op_sel`=0) shifts a zero into bit 0 at the class width (class 0 = 36 bits, 1 = 32 bits, 2 or 3 = 16 bits). N is the result bit at class width minus one. Z is set when the class-width result is zero.
- R3: On arithmetic left, C is the source MSB at the class width (bit 35, 31 or 15). V is set exactly when the result MSB differs from the source MSB.
- R4: Arithmetic right (`op_sel`=1) copies the source MSB into the MSB and the MSB-1 position. C is source bit 0, V is cleared, and N and Z follow the class-width result as in R2.
- R5: Logical and rotate operations (`op_sel` 2 = logical left, 3 = logical right, 4 = rotate left, 5 = rotate right) act on bits 31:16 for classes 0 and 1 and on bits 15:0 for classes 2 and 3. Logical steps insert 0 into the vacated bit; rotates insert `carry_in`.
- R6: For logical and rotate steps, a left step takes C from word bit 15 (operand bit 31 for classes 0 and 1, bit 15 otherwise). A right step takes C from word bit 0 (operand bit 16 for classes 0 and 1, bit 0 otherwise). N is the new word's bit 15, Z is set when the new word is zero, and V is cleared.
- R7: A logical or rotate step on the accumulator leaves result bits 35:32 and 15:0 equal to the operand.
- R8: Operand bits above the class width are ignored and read as zero in `result`. `carry_in` has no effect on operations other than rotates.
- R9: Unused op codes 6 and 7 return the operand masked to the class width with all four flags cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 3 | Operation code (0..5, 6/7 unused) |
| opnd_class | input | 2 | 0 accumulator, 1 32-bit, 2/3 16-bit |
| operand | input | ACC_W (36) | Source value |
| carry_in | input | 1 | Bit inserted by rotates |
| out_valid | output | 1 | Result valid |
| result | output | ACC_W (36) | Shifted value |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The assertions take for granted that `op_sel`, `opnd_class` and `operand` are defined, not X, whenever `in_valid` is high. They also assume the class code alone decides how much of the operand is meaningful, so garbage above the class width must have no effect. The stimulus draws every field from the full range of its port, including the unused op codes, class code 3 and random upper bits. Directed cases add sign-boundary values, all-zero and all-one words, and paired requests that differ only in ignored bits or in `carry_in`.

// File: rtl/shr_pkg.sv
package shr_pkg;

  typedef enum logic [2:0] {
    OP_ASL  = 3'd0,
    OP_ASR  = 3'd1,
    OP_LSL  = 3'd2,
    OP_LSR  = 3'd3,
    OP_ROL  = 3'd4,
    OP_ROR  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } shr_op_e;

  typedef enum logic [1:0] {
    CLS_ACC  = 2'd0,
    CLS_R32  = 2'd1,
    CLS_R16  = 2'd2,
    CLS_R16B = 2'd3
  } shr_cls_e;

  typedef struct packed {
    logic c;
    logic v;
    logic n;
    logic z;
  } shr_flags_t;

  localparam int NUM_LANES = 3;

endpackage

// File: rtl/shr_arith_lane.sv
module shr_arith_lane #(
  parameter int W = 36
) (
  input  logic [W-1:0] src,
  input  logic         go_right,
  output logic [W-1:0] res,
  output logic         c_out,
  output logic         v_out
);
  always_comb begin
    if (go_right) begin
      res   = {src[W-1], src[W-1:1]};
      c_out = src[0];
      v_out = 1'b0;
    end else begin
      res   = {src[W-2:0], 1'b0};
      c_out = src[W-1];
      v_out = src[W-1] ^ src[W-2];
    end
  end
endmodule

// File: rtl/shr_word_rot.sv
module shr_word_rot #(
  parameter int W = 16
) (
  input  logic [W-1:0] word_in,
  input  logic         go_right,
  input  logic         rotate,
  input  logic         cin,
  output logic [W-1:0] word_out,
  output logic         c_out
);
  logic fill_bit;
  assign fill_bit = rotate & cin;

  always_comb begin
    if (go_right) begin
      word_out = {fill_bit, word_in[W-1:1]};
      c_out    = word_in[0];
    end else begin
      word_out = {word_in[W-2:0], fill_bit};
      c_out    = word_in[W-1];
    end
  end
endmodule

// File: rtl/shr_unit.sv
module shr_unit
  import shr_pkg::*;
#(
  parameter int ACC_W  = 36,
  parameter int REG_W  = 32,
  parameter int WORD_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [2:0]       op_sel,
  input  logic [1:0]       opnd_class,
  input  logic [ACC_W-1:0] operand,
  input  logic             carry_in,
  output logic             out_valid,
  output logic [ACC_W-1:0] result,
  output logic             flag_c,
  output logic             flag_v,
  output logic             flag_n,
  output logic             flag_z
);
  localparam int HI_LSB = WORD_W;
  localparam int HI_MSB = 2 * WORD_W - 1;

  function automatic int lane_width(input logic [1:0] idx);
    case (idx)
      2'd0:    return ACC_W;
      2'd1:    return REG_W;
      default: return WORD_W;
    endcase
  endfunction

  function automatic logic [ACC_W-1:0] width_mask(input int w);
    logic [ACC_W-1:0] m;
    for (int i = 0; i < ACC_W; i++) m[i] = (i < w);
    return m;
  endfunction

  shr_op_e op;
  assign op = shr_op_e'(op_sel);

  logic [1:0] lane_idx;
  logic       go_right, is_arith, is_word, is_rotate, wide_word;
  assign lane_idx  = (opnd_class == CLS_ACC) ? 2'd0 :
                     (opnd_class == CLS_R32) ? 2'd1 : 2'd2;
  assign go_right  = (op == OP_ASR) || (op == OP_LSR) || (op == OP_ROR);
  assign is_arith  = (op == OP_ASL) || (op == OP_ASR);
  assign is_rotate = (op == OP_ROL) || (op == OP_ROR);
  assign is_word   = (op == OP_LSL) || (op == OP_LSR) || is_rotate;
  assign wide_word = (lane_idx != 2'd2);

  logic [ACC_W-1:0] lane_res [NUM_LANES];
  logic             lane_c   [NUM_LANES];
  logic             lane_v   [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int LW = (g == 0) ? ACC_W : (g == 1) ? REG_W : WORD_W;
    logic [LW-1:0] lres;
    shr_arith_lane #(.W(LW)) u_lane (
      .src      (operand[LW-1:0]),
      .go_right (go_right),
      .res      (lres),
      .c_out    (lane_c[g]),
      .v_out    (lane_v[g])
    );
    assign lane_res[g] = ACC_W'(lres);
  end

  logic [ACC_W-1:0] arith_res;
  logic             arith_c, arith_v;
  assign arith_res = lane_res[lane_idx];
  assign arith_c   = lane_c[lane_idx];
  assign arith_v   = lane_v[lane_idx];

  logic [WORD_W-1:0] word_src, word_new;
  logic              word_c;
  assign word_src = wide_word ? operand[HI_MSB:HI_LSB] : operand[WORD_W-1:0];

  shr_word_rot #(.W(WORD_W)) u_word (
    .word_in  (word_src),
    .go_right (go_right),
    .rotate   (is_rotate),
    .cin      (carry_in),
    .word_out (word_new),
    .c_out    (word_c)
  );

  logic [ACC_W-1:0] class_masked;
  logic [ACC_W-1:0] word_res;
  assign class_masked = operand & width_mask(lane_width(lane_idx));

  always_comb begin
    word_res = class_masked;
    if (wide_word) word_res[HI_MSB:HI_LSB] = word_new;
    else           word_res[WORD_W-1:0]   = word_new;
  end

  logic [ACC_W-1:0] nx_result;
  shr_flags_t       nx_flags;

  always_comb begin
    if (is_arith) begin
      nx_result  = arith_res;
      nx_flags.c = arith_c;
      nx_flags.v = arith_v;
      nx_flags.n = arith_res[lane_width(lane_idx) - 1];
      nx_flags.z = (arith_res == '0);
    end else if (is_word) begin
      nx_result  = word_res;
      nx_flags.c = word_c;
      nx_flags.v = 1'b0;
      nx_flags.n = word_new[WORD_W-1];
      nx_flags.z = (word_new == '0);
    end else begin
      nx_result  = class_masked;
      nx_flags   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_c    <= 1'b0;
      flag_v    <= 1'b0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nx_result;
        flag_c <= nx_flags.c;
        flag_v <= nx_flags.v;
        flag_n <= nx_flags.n;
        flag_z <= nx_flags.z;
      end
    end
  end

endmodule

// File: rtl/shr_unit_chk.sv
module shr_unit_chk #(
  parameter int ACC_W = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [2:0]       op_sel,
  input logic [1:0]       opnd_class,
  input logic [ACC_W-1:0] operand,
  input logic             out_valid,
  input logic [ACC_W-1:0] result,
  input logic             flag_c,
  input logic             flag_v
);
  logic req_word, req_acc, req_narrow;
  assign req_word   = in_valid && (op_sel >= 3'd2) && (op_sel <= 3'd5);
  assign req_acc    = (opnd_class == 2'd0);
  assign req_narrow = (opnd_class != 2'd0);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R1

  AST_ASL_ACC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_sel == 3'd0 && req_acc |=> flag_c == $past(operand[ACC_W-1])); // R3

  AST_ASR_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_sel == 3'd1 |=> !flag_v); // R4

  AST_WORD_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    req_word |=> !flag_v); // R6

  AST_ACC_WORD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    req_word && req_acc |=> result[15:0] == $past(operand[15:0])
                           && result[ACC_W-1:32] == $past(operand[ACC_W-1:32])); // R7

  AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && req_narrow |=> result[ACC_W-1:32] == '0); // R8

endmodule

bind shr_unit shr_unit_chk #(.ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .op_sel     (op_sel),
  .opnd_class (opnd_class),
  .operand    (operand),
  .out_valid  (out_valid),
  .result     (result),
  .flag_c     (flag_c),
  .flag_v     (flag_v)
);

// File: tb/shr_unit_bench.sv
`timescale 1ns/1ps
module shr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [1:0]  opnd_class = '0;
  logic [35:0] operand = '0;
  logic        carry_in = 1'b0;
  logic        out_valid;
  logic [35:0] result;
  logic        flag_c, flag_v, flag_n, flag_z;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  shr_unit u_shr_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .opnd_class(opnd_class), .operand(operand), .carry_in(carry_in),
    .out_valid(out_valid), .result(result), .flag_c(flag_c),
    .flag_v(flag_v), .flag_n(flag_n), .flag_z(flag_z)
  );

  typedef struct {
    logic [35:0] r;
    logic c, v, n, z;
  } exp_t;

  function automatic exp_t model(input logic [2:0] o, input logic [1:0] k,
                                 input logic [35:0] x, input logic ci);
    exp_t e;
    int w = (k == 2'd0) ? 36 : (k == 2'd1) ? 32 : 16;
    logic [35:0] m = (w == 36) ? {36{1'b1}} : ((36'd1 << w) - 36'd1);
    logic [35:0] s = x & m;
    int base = (k == 2'd2 || k == 2'd3) ? 0 : 16;
    logic [15:0] wd = s[base +: 16];
    logic [15:0] nw;
    e.r = s; e.c = 0; e.v = 0; e.n = 0; e.z = 0;
    case (o)
      3'd0: begin
        e.r = (s << 1) & m;
        e.c = s[w-1];
        e.v = (s[w-1] != s[w-2]);
        e.n = e.r[w-1];
        e.z = (e.r == 0);
      end
      3'd1: begin
        e.r = (s >> 1) | (s[w-1] ? (36'd1 << (w-1)) : 36'd0);
        e.c = s[0];
        e.n = e.r[w-1];
        e.z = (e.r == 0);
      end
      3'd2, 3'd3, 3'd4, 3'd5: begin
        logic fill = (o >= 3'd4) ? ci : 1'b0;
        if (o == 3'd2 || o == 3'd4) begin
          nw = {wd[14:0], fill}; e.c = wd[15];
        end else begin
          nw = {fill, wd[15:1]}; e.c = wd[0];
        end
        e.r[base +: 16] = nw;
        e.n = nw[15];
        e.z = (nw == 0);
      end
      default: ;
    endcase
    return e;
  endfunction

  function automatic string tag_for(input logic [2:0] o, input bit flag);
    if (o == 3'd0) return flag ? "R3" : "R2";
    if (o == 3'd1) return "R4";
    if (o <= 3'd5) return flag ? "R6" : "R5";
    return "R9";
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_one(input logic [2:0] o, input logic [1:0] k,
                         input logic [35:0] x, input logic ci);
    exp_t e;
    op_sel = o; opnd_class = k; operand = x; carry_in = ci; in_valid = 1'b1;
    e = model(o, k, x, ci);
    @(negedge clk);
    check("R1", "out_valid", 36'(out_valid), 36'd1);
    check(tag_for(o, 0), "result", result, e.r);
    check(tag_for(o, 1), "flag_c", 36'(flag_c), 36'(e.c));
    check(o == 3'd0 ? "R3" : tag_for(o, 1), "flag_v", 36'(flag_v), 36'(e.v));
    check(o <= 3'd1 ? tag_for(o, 0) : tag_for(o, 1), "flag_n", 36'(flag_n), 36'(e.n));
    check(o <= 3'd1 ? tag_for(o, 0) : tag_for(o, 1), "flag_z", 36'(flag_z), 36'(e.z));
    if (k == 2'd0 && o >= 3'd2 && o <= 3'd5) begin
      check("R7", "acc low word", 36'(result[15:0]), 36'(x[15:0]));
      check("R7", "acc ext", 36'(result[35:32]), 36'(x[35:32]));
    end
  endtask

  task automatic idle_one();
    logic [35:0] held = result;
    in_valid = 1'b0;
    operand = {$urandom, $urandom};
    @(negedge clk);
    check("R1", "idle out_valid", 36'(out_valid), 36'd0);
    check("R1", "idle hold", result, held);
  endtask

  task automatic pair_same(input string tag, input logic [2:0] o, input logic [1:0] k,
                           input logic [35:0] xa, input logic ca,
                           input logic [35:0] xb, input logic cb);
    logic [35:0] ra;
    logic [3:0]  fa;
    run_one(o, k, xa, ca);
    ra = result; fa = {flag_c, flag_v, flag_n, flag_z};
    run_one(o, k, xb, cb);
    check(tag, "ignored input result", result, ra);
    check(tag, "ignored input flags", 36'({flag_c, flag_v, flag_n, flag_z}), 36'(fa));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    check("R1", "reset out_valid", 36'(out_valid), 36'd0);
    check("R1", "reset result", result, 36'd0);
    check("R1", "reset flags", 36'({flag_c, flag_v, flag_n, flag_z}), 36'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "no request", 36'(out_valid), 36'd0);

    // Directed corner cases
    run_one(3'd0, 2'd0, 36'h4_0000_0000, 1'b0);   // R3 acc sign flips -> V
    run_one(3'd0, 2'd0, 36'h8_0000_0000, 1'b1);   // R2 result zero, C=1
    run_one(3'd0, 2'd1, 36'hF_4000_0000, 1'b0);   // R3 32-bit V, upper ignored
    run_one(3'd0, 2'd2, 36'h0_0000_C000, 1'b0);   // R3 16-bit no V
    run_one(3'd1, 2'd0, 36'h8_0000_0001, 1'b0);   // R4 sign copy, C=1
    run_one(3'd1, 2'd1, 36'h0_8000_0000, 1'b0);   // R4 32-bit sign
    run_one(3'd1, 2'd3, 36'h0_0000_0001, 1'b0);   // R4 result zero
    run_one(3'd2, 2'd0, 36'hA_8000_1234, 1'b1);   // R6 C from bit 31
    run_one(3'd3, 2'd0, 36'h5_0001_FFFF, 1'b1);   // R6 C from bit 16, Z
    run_one(3'd4, 2'd0, 36'h3_7FFF_0F0F, 1'b1);   // R5 rotate in carry
    run_one(3'd5, 2'd1, 36'hF_0000_AAAA, 1'b1);   // R5 rotate right 32-bit class
    run_one(3'd4, 2'd2, 36'h0_0000_8000, 1'b0);   // R6 16-bit C, Z
    run_one(3'd5, 2'd2, 36'h0_0000_0001, 1'b1);   // R5 N from carry
    run_one(3'd6, 2'd1, 36'hF_FFFF_FFFF, 1'b1);   // R9
    run_one(3'd7, 2'd2, 36'h1_2345_6789, 1'b0);   // R9
    idle_one();
    pair_same("R8", 3'd0, 2'd2, 36'h0_0000_4321, 1'b0, 36'hF_FFFF_4321, 1'b0);
    pair_same("R8", 3'd1, 2'd1, 36'h0_8765_4321, 1'b0, 36'hA_8765_4321, 1'b1);
    pair_same("R8", 3'd2, 2'd0, 36'h5_1234_5678, 1'b0, 36'h5_1234_5678, 1'b1);
    pair_same("R8", 3'd3, 2'd3, 36'h0_0000_F00F, 1'b1, 36'h9_ABCD_F00F, 1'b0);

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 10) == 0) idle_one();
      else run_one(3'($urandom % 8), 2'($urandom % 4),
                   {4'($urandom), 32'($urandom)}, 1'($urandom));
    end

    in_valid = 1'b0;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule